// File: doc/BRIEF.md
# Tower-Field AES Forward Substitution Byte

This block computes the AES forward substitution of one byte with no lookup table. The incoming byte goes through a fixed 8x8 bit-matrix that moves it into a composite representation. In that representation GF(2^8) is built as a quadratic extension of GF(2^4), and GF(2^4) is built as a quadratic extension of GF(2^2). The multiplicative inverse is then formed from 4-bit multiply, square and constant-scale operators, and the single 4-bit inverse inside them comes from 2-bit operators alone. A second fixed matrix returns the inverse to the standard polynomial basis. The AES affine transform is folded into that second matrix, and its 0x63 constant is added at the end.

All basis-change matrices and the extension constant are derived from the field arithmetic when the design is elaborated. No table is written out in the source. The datapath narrows from 8 bits to 4 and 2 bits and widens back to 8. A parameter chooses whether the result is registered on a flop bank with asynchronous active-low reset, which gives one cycle of latency, or is passed straight to the output.

Top module: `sbox_tower`

## Requirements
- R1: With `REG_OUT=1`, `out_o` is 0x00 while `rst_ni` is low, and it clears as soon as reset is asserted, without waiting for a clock edge.
- R2: With `REG_OUT=1`, `out_o` after a rising edge equals the standard AES forward S-box of the `in_i` value sampled at that edge, for each of the 256 byte values.
- R3: Input 0x00, whose inverse is defined as 0, produces 0x63. No other input produces 0x63.
- R4: Input 0x53 produces 0xed, and input 0x01 produces 0x7c.
- R5: No byte maps to itself: the output differs from the input for every value.
- R6: The mapping is a permutation: the 256 inputs give 256 distinct outputs, and two different consecutive inputs never give equal consecutive outputs.
- R7: With `REG_OUT=0`, `out_o` equals the S-box of the present `in_i` in the same cycle, whatever the reset state.
- R8: With `REG_OUT=1`, an input held constant across edges leaves `out_o` constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| in_i | input | 8 | Byte to substitute |
| out_o | output | 8 | Substituted byte |

## Verification
Two events can fall on the same cycle here: an asynchronous reset clearing the output register, and a fresh byte being captured. The bench asserts reset between edges while a non-zero byte is applied. It then expects the registered copy at 0x00 at once, while the unregistered copy keeps substituting the same byte. After release, it expects the next edge to capture the byte held on the input. The behavioural model computes the inverse by exhaustive search in the AES polynomial field and applies the affine step bit by bit. It is compared against both the registered and the unregistered instance on every clock of a full 256-value sweep.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  typedef logic [1:0]      gf4_t;
  typedef logic [3:0]      gf16_t;
  typedef logic [7:0]      byte_t;
  typedef logic [7:0][7:0] bmat_t;  // column i = image of input bit i

  localparam byte_t AFF_C = 8'h63;

  // GF(4): x^2 + x + 1, element {b1,b0} = b1*x + b0
  function automatic gf4_t gf4_mul(input gf4_t a, input gf4_t b);
    gf4_t r;
    r[1] = (a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]);
    r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
    return r;
  endfunction

  // squaring equals inversion in GF(4)
  function automatic gf4_t gf4_sq(input gf4_t a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // scale by phi = x
  function automatic gf4_t gf4_phi(input gf4_t a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // GF(16) = GF(4)[y]/(y^2 + y + phi)
  function automatic gf16_t gf16_mul(input gf16_t a, input gf16_t b);
    gf4_t hh;
    gf16_t r;
    hh      = gf4_mul(a[3:2], b[3:2]);
    r[3:2]  = hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]);
    r[1:0]  = gf4_phi(hh) ^ gf4_mul(a[1:0], b[1:0]);
    return r;
  endfunction

  // smallest lambda making z^2 + z + lambda irreducible over GF(16)
  function automatic gf16_t find_lambda();
    gf16_t res;
    bit    has_root;
    res = 4'h0;
    for (int l = 15; l >= 1; l--) begin
      has_root = 1'b0;
      for (int z = 0; z < 16; z++)
        if ((gf16_mul(4'(z), 4'(z)) ^ 4'(z)) == 4'(l)) has_root = 1'b1;
      if (!has_root) res = 4'(l);
    end
    return res;
  endfunction

  localparam gf16_t TOWER_LAMBDA = find_lambda();

  // GF(256) = GF(16)[z]/(z^2 + z + lambda), elaboration use only
  function automatic byte_t tower_mul(input byte_t a, input byte_t b);
    gf16_t hh;
    byte_t r;
    hh     = gf16_mul(a[7:4], b[7:4]);
    r[7:4] = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
    r[3:0] = gf16_mul(TOWER_LAMBDA, hh) ^ gf16_mul(a[3:0], b[3:0]);
    return r;
  endfunction

  // a root of x^8 + x^4 + x^3 + x + 1 inside the tower field
  function automatic byte_t find_root();
    byte_t res, c, c2, c3, c4, c8;
    res = 8'h00;
    for (int k = 255; k >= 2; k--) begin
      c  = 8'(k);
      c2 = tower_mul(c, c);
      c3 = tower_mul(c2, c);
      c4 = tower_mul(c2, c2);
      c8 = tower_mul(c4, c4);
      if ((c8 ^ c4 ^ c3 ^ c ^ 8'h01) == 8'h00) res = c;
    end
    return res;
  endfunction

  function automatic byte_t mat_apply(input bmat_t m, input byte_t v);
    byte_t acc;
    acc = 8'h00;
    for (int i = 0; i < 8; i++)
      if (v[i]) acc ^= m[i];
    return acc;
  endfunction

  function automatic bmat_t build_to_tower();
    bmat_t m;
    byte_t beta, pw;
    beta = find_root();
    pw   = 8'h01;
    for (int i = 0; i < 8; i++) begin
      m[i] = pw;
      pw   = tower_mul(pw, beta);
    end
    return m;
  endfunction

  localparam bmat_t TO_TOWER = build_to_tower();

  function automatic byte_t aff_lin(input byte_t b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
  endfunction

  // inverse basis change merged with the affine matrix
  function automatic bmat_t build_from_tower();
    bmat_t m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (mat_apply(TO_TOWER, 8'(a)) == (8'h01 << j)) m[j] = aff_lin(8'(a));
    return m;
  endfunction

  localparam bmat_t FROM_TOWER_AFF = build_from_tower();

endpackage

// File: rtl/sbox_lin_map.sv
module sbox_lin_map #(
  parameter int                W     = 8,
  parameter logic [W-1:0][W-1:0] COLS  = '0,
  parameter logic [W-1:0]      OFFS  = '0
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  always_comb begin
    d_o = OFFS;
    for (int i = 0; i < W; i++)
      if (d_i[i]) d_o ^= COLS[i];
  end
endmodule

// File: rtl/sbox_gf16_inv.sv
module sbox_gf16_inv
  import sbox_pkg::*;
(
  input  gf16_t a_i,
  output gf16_t inv_o
);
  gf4_t ah, al, d, d_inv;

  assign ah    = a_i[3:2];
  assign al    = a_i[1:0];
  assign d     = gf4_phi(gf4_sq(ah)) ^ gf4_mul(ah, al) ^ gf4_sq(al);
  assign d_inv = gf4_sq(d);
  assign inv_o = {gf4_mul(ah, d_inv), gf4_mul(ah ^ al, d_inv)};
endmodule

// File: rtl/sbox_gf256_inv.sv
module sbox_gf256_inv
  import sbox_pkg::*;
#(
  parameter gf16_t LAMBDA = TOWER_LAMBDA
) (
  input  byte_t a_i,
  output byte_t inv_o
);
  gf16_t ah, al, d, d_inv;

  assign ah = a_i[7:4];
  assign al = a_i[3:0];
  assign d  = gf16_mul(LAMBDA, gf16_mul(ah, ah)) ^ gf16_mul(ah, al) ^ gf16_mul(al, al);

  sbox_gf16_inv u_inv16 (
    .a_i   (d),
    .inv_o (d_inv)
  );

  assign inv_o = {gf16_mul(ah, d_inv), gf16_mul(ah ^ al, d_inv)};
endmodule

// File: rtl/sbox_tower.sv
module sbox_tower
  import sbox_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  byte_t t_in, t_inv, sb;

  sbox_lin_map #(.W(8), .COLS(TO_TOWER), .OFFS(8'h00)) u_map_in (
    .d_i (in_i),
    .d_o (t_in)
  );

  sbox_gf256_inv #(.LAMBDA(TOWER_LAMBDA)) u_inv (
    .a_i   (t_in),
    .inv_o (t_inv)
  );

  sbox_lin_map #(.W(8), .COLS(FROM_TOWER_AFF), .OFFS(AFF_C)) u_map_out (
    .d_i (t_inv),
    .d_o (sb)
  );

  generate
    if (REG_OUT) begin : g_reg
      byte_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 8'h00;
        else         q <= sb;
      end
      assign out_o = q;
    end else begin : g_comb
      assign out_o = sb;
    end
  endgenerate
endmodule

// File: rtl/sbox_tower_chk.sv
module sbox_tower_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] in_i,
  input logic [7:0] out_o
);
  generate
    if (REG_OUT) begin : g_reg
      a_r1_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |-> out_o == 8'h00);
      a_r3_zero_maps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(in_i) == 8'h00 |-> out_o == 8'h63);
      a_r3_only_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(in_i) != 8'h00 |-> out_o != 8'h63);
      a_r5_no_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> out_o != $past(in_i));
      a_r6_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni, 2) && $past(rst_ni) && $past(in_i) != $past(in_i, 2)
        |-> out_o != $past(out_o));
      a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $stable(in_i) |=> $stable(out_o));
    end else begin : g_comb
      a_r7_zero_maps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_i == 8'h00 |-> out_o == 8'h63);
      a_r7_no_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_o != in_i);
      a_r7_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(in_i) != in_i |-> $past(out_o) != out_o);
    end
  endgenerate
endmodule

bind sbox_tower sbox_tower_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .in_i   (in_i),
  .out_o  (out_o)
);

// File: tb/sim_sbox_tower.sv
module sim_sbox_tower;
  logic       clk_i  = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_r   = 8'h00;
  logic [7:0] u0_out, u1_out;
  int n_chk  = 0;
  int n_fail = 0;
  bit seen [256];

  always #2 clk_i = ~clk_i;

  sbox_tower #(.REG_OUT(1'b1)) u0 (.clk_i(clk_i), .rst_ni(rst_ni), .in_i(in_r), .out_o(u0_out));
  sbox_tower #(.REG_OUT(1'b0)) u1 (.clk_i(clk_i), .rst_ni(rst_ni), .in_i(in_r), .out_o(u1_out));

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = xtime(x);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] v);
    logic [7:0] inv = 8'h00, s, c = 8'h63;
    for (int k = 1; k < 256; k++)
      if (fmul(v, 8'(k)) == 8'h01) inv = 8'(k);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h (in %02h)", req, act, exp, in_r);
    end
  endtask

  // drive between edges, sample 1 ns after the capturing edge
  task automatic step(input logic [7:0] v);
    logic [7:0] e;
    @(negedge clk_i);
    in_r = v;
    e = ref_sbox(v);
    @(posedge clk_i);
    #1;
    chk(u0_out == e, "R2", u0_out, e);
    chk(u1_out == e, "R7", u1_out, e);
    chk(u0_out != v, "R5", u0_out, v);
    if (v == 8'h00) chk(u0_out == 8'h63, "R3", u0_out, 8'h63);
    else            chk(u0_out != 8'h63, "R3", u0_out, 8'h63);
    if (v == 8'h53) chk(u0_out == 8'hed, "R4", u0_out, 8'hed);
    if (v == 8'h01) chk(u0_out == 8'h7c, "R4", u0_out, 8'h7c);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int distinct;
    logic [7:0] held;
    in_r = 8'h00;
    repeat (3) @(posedge clk_i);
    #1;
    chk(u0_out == 8'h00, "R1", u0_out, 8'h00);
    chk(u1_out == 8'h63, "R7", u1_out, 8'h63);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < 256; v++) begin
      step(8'(v));
      seen[u0_out] = 1'b1;
    end
    distinct = 0;
    for (int k = 0; k < 256; k++) if (seen[k]) distinct++;
    chk(distinct == 256, "R6", 8'(distinct), 8'h00);

    // walking ones, then alternating patterns
    for (int i = 0; i < 8; i++) step(8'h01 << i);
    step(8'haa); step(8'h55); step(8'h53); step(8'h00); step(8'hff);

    // hold input: registered output must not move
    step(8'ha5);
    held = u0_out;
    repeat (4) begin
      @(posedge clk_i);
      #1;
      chk(u0_out == held, "R8", u0_out, held);
    end

    // reset between edges with a live byte applied
    step(8'h3c);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(u0_out == 8'h00, "R1", u0_out, 8'h00);
    chk(u1_out == ref_sbox(8'h3c), "R7", u1_out, ref_sbox(8'h3c));
    @(posedge clk_i);
    #1;
    chk(u0_out == 8'h00, "R1", u0_out, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk(u0_out == ref_sbox(8'h3c), "R2", u0_out, ref_sbox(8'h3c));
    step(8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule